// File: doc/BRIEF.md
# Level-Following Masked Interrupt Aggregator

This block gathers a parameterised set of level-sensitive interrupt request lines, at most 32, into a pending word. It gates that word with a mask that software writes, and it drives one interrupt line towards the processor. Each pending bit follows its input level. A bit is high while the line is high and low once the line drops, so software has nothing to clear. The request lines may come from other clock domains, so a synchroniser stage sits in front of the pending register.

Software reaches the block through a plain 32-bit register port. Each access is one cycle with no stall. A read strobe returns data on the following cycle, marked by a valid flag. The port exposes a read/write mask word and a read-only status word that mirrors the pending bits. Two further write locations accept data and discard it. Every other location reads as zero and ignores writes. All decoding is exact on a byte address, so only aligned full-word accesses reach a register.

Top module: `lvl_irq_agg`

## Requirements
- R1: Each pending bit follows its input level with no latching. A change on `irq_lines` is visible in the pending word three clock edges later: two synchroniser edges, then the pending register edge. When the input falls, the bit clears by the same path.
- R2: `cpu_irq` is high exactly when some bit of (mask AND pending) is set. It is a register, so it shows that condition one clock edge after the mask or pending word changes.
- R3: Byte offset 0x04 holds the mask. A write there replaces all implemented bits with `bus_wdata[NUM_LINES-1:0]`, and a read returns them. Bits at NUM_LINES and above always read as 0.
- R4: Byte offset 0x0C is the status word. A read returns the pending bits in bit positions 0 to NUM_LINES-1. Writes to it change nothing.
- R5: Writes to byte offsets 0x00 and 0x14 are accepted and change no state. The mask and `cpu_irq` stay as they were.
- R6: A read of any byte address other than 0x04 and 0x0C returns 0. This includes 0x00, 0x14, 0x08 and unaligned addresses such as 0x05. Writes to any such address are ignored.
- R7: `bus_rvalid` is high on exactly the cycle after each cycle with `bus_rd_en` high. `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R8: While `rst_n` is low, the mask, the synchroniser, the pending word, `cpu_irq` and `bus_rvalid` are all 0. After release, the mask reads 0 and `cpu_irq` stays low until a mask bit and a pending bit are both set.
- R9: A read and a mask write issued in the same cycle to offset 0x04 return the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive request lines, possibly asynchronous |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High on the cycle after a read strobe |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
A mask write and a change in the pending word can land on the same clock edge. The bench provokes this by timing a request line so that it reaches the pending register on the very edge that samples a mask write. One run sets both together and another clears both together. In each case `cpu_irq` must keep its old value on the cycle straight after that edge and take the combined new value one cycle later. A read of the mask issued in the same cycle as a write to it is also checked, and it must return the value from before the write.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

   localparam int unsigned BUS_W = 32;

   // byte offsets; decoding is exact, so unaligned addresses hit nothing
   localparam logic [31:0] OFS_LEVEL  = 32'h0000_0000;
   localparam logic [31:0] OFS_MASK   = 32'h0000_0004;
   localparam logic [31:0] OFS_STATUS = 32'h0000_000C;
   localparam logic [31:0] OFS_CTRL   = 32'h0000_0014;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LEVEL,
      SEL_MASK,
      SEL_STATUS,
      SEL_CTRL
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] a);
      reg_sel_e s;
      case (a)
         OFS_LEVEL:  s = SEL_LEVEL;
         OFS_MASK:   s = SEL_MASK;
         OFS_STATUS: s = SEL_STATUS;
         OFS_CTRL:   s = SEL_CTRL;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lines_i,
   output logic [WIDTH-1:0] pend_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("lvl_irq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lvl_irq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= lines_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   // pending word: plain level copy, no sticky bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= chain[LAST];
   end

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
   import lvl_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [31:0]          addr_i,
   input  logic                 wr_en_i,
   input  logic [BUS_W-1:0]     wdata_i,
   input  logic                 rd_en_i,
   input  logic [NUM_LINES-1:0] pend_i,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [BUS_W-1:0]     rdata_o,
   output logic                 rvalid_o
);

   reg_sel_e         sel;
   logic [BUS_W-1:0] mask_ext;
   logic [BUS_W-1:0] pend_ext;
   logic [BUS_W-1:0] rd_mux;
   logic             unused_wdata;

   assign sel          = decode_addr(addr_i);
   assign unused_wdata = ^wdata_i;

   // mask register: only the mask offset writes; level/ctrl/status writes drop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mask_o <= '0;
      else if (wr_en_i && sel == SEL_MASK) mask_o <= wdata_i[NUM_LINES-1:0];
   end

   always_comb begin
      mask_ext                  = '0;
      pend_ext                  = '0;
      mask_ext[NUM_LINES-1:0]   = mask_o;
      pend_ext[NUM_LINES-1:0]   = pend_i;
      case (sel)
         SEL_MASK:   rd_mux = mask_ext;
         SEL_STATUS: rd_mux = pend_ext;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= rd_en_i;
         rdata_o  <= rd_en_i ? rd_mux : '0;
      end
   end

   // R3
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && sel == SEL_MASK) |=> (mask_o == $past(wdata_i[NUM_LINES-1:0])));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && sel == SEL_MASK) |=> $stable(mask_o));

endmodule

// File: rtl/lvl_irq_out.sv
module lvl_irq_out #(
   parameter int unsigned NUM_LINES = 32,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] pend_i,
   output logic                 irq_o
);

   logic hit;
   assign hit = |(mask_i & pend_i);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= hit;
      end
   end else begin : g_comb
      assign irq_o = hit;
   end

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
   import lvl_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 24,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr_en,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_rd_en,
   output logic [31:0]          bus_rdata,
   output logic                 bus_rvalid,
   output logic                 cpu_irq
);

   if (NUM_LINES < 1 || NUM_LINES > BUS_W) begin : g_bad_lines
      $error("lvl_irq_agg: NUM_LINES must be 1..32");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("lvl_irq_agg: ADDR_W must be 5..32");
   end

   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] mask;
   logic [31:0]          addr_full;

   assign addr_full = 32'(bus_addr);

   lvl_irq_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (irq_lines),
      .pend_o  (pend)
   );

   lvl_irq_regs #(
      .NUM_LINES (NUM_LINES)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (addr_full),
      .wr_en_i  (bus_wr_en),
      .wdata_i  (bus_wdata),
      .rd_en_i  (bus_rd_en),
      .pend_i   (pend),
      .mask_o   (mask),
      .rdata_o  (bus_rdata),
      .rvalid_o (bus_rvalid)
   );

   lvl_irq_out #(
      .NUM_LINES (NUM_LINES),
      .OUT_REG   (OUT_REG)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_i (mask),
      .pend_i (pend),
      .irq_o  (cpu_irq)
   );

   if (OUT_REG) begin : g_reg_chk
      // R2
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq == (|($past(mask) & $past(pend))));
      // R8
      irq_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(rst_n) |-> !cpu_irq);
   end

   // R7
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);
   // R7
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> !bus_rvalid);
   // R7
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid |-> (bus_rdata == '0));

   if (NUM_LINES < BUS_W) begin : g_hi_chk
      // R3
      rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[BUS_W-1:NUM_LINES] == '0);
   end

endmodule

// File: tb/lvl_irq_agg_bench.sv
module lvl_irq_agg_bench;

   localparam int NL = 24;
   localparam int AW = 8;
   localparam logic [31:0] LINE_ONES = 32'h00FF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_lines = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr_en = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd_en = 1'b0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic          cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   lvl_irq_agg #(.NUM_LINES(NL), .ADDR_W(AW)) u_lvl_irq_agg (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_lines  (irq_lines),
      .bus_addr   (bus_addr),
      .bus_wr_en  (bus_wr_en),
      .bus_wdata  (bus_wdata),
      .bus_rd_en  (bus_rd_en),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .cpu_irq    (cpu_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_rvalid) begin
            if (sb.size() == 0) begin
               check("R7 unexpected rvalid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, bus_rdata, e.val);
            end
         end else if (bus_rdata !== '0) begin
            check("R7 idle rdata", bus_rdata, 32'd0);
         end
      end
   end

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a[AW-1:0];
      bus_wdata = d;
      bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      bus_addr  = a[AW-1:0];
      bus_rd_en = 1'b1;
      e.val = exp;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state, with requests already high
      irq_lines = '1;
      repeat (3) @(negedge clk);
      check("R8 irq in reset", {31'd0, cpu_irq}, 32'd0);
      check("R8 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
      rst_n = 1'b1;
      bus_read(32'h0C, 32'd0, "R8 status right after reset");
      bus_read(32'h04, 32'd0, "R8 mask after reset");
      check("R8 irq low, mask zero", {31'd0, cpu_irq}, 32'd0);
      irq_lines = '0;
      settle();

      // R3: full replace, upper bits read zero
      bus_write(32'h04, 32'hFFFF_FFFF);
      bus_read(32'h04, LINE_ONES, "R3 mask all ones");
      bus_write(32'h04, 32'h0000_00F0);
      bus_read(32'h04, 32'h0000_00F0, "R3 mask replaced");

      // R1/R2: latency from line to cpu_irq with mask already covering it
      @(negedge clk);
      irq_lines = 24'h000010;               // before edge E1
      repeat (3) @(negedge clk);            // after E3: pending set
      check("R2 irq one cycle after pending", {31'd0, cpu_irq}, 32'd0);
      @(negedge clk);                       // after E4
      check("R1 R2 irq after sync path", {31'd0, cpu_irq}, 32'd1);
      bus_read(32'h0C, 32'h0000_0010, "R4 status mirrors pending");

      // R2: masked-off line raises nothing; mask write latency
      irq_lines = 24'h000005;
      settle();
      check("R2 masked line", {31'd0, cpu_irq}, 32'd0);
      bus_read(32'h0C, 32'h0000_0005, "R1 pending follows level");
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = 32'h0000_0004; bus_wr_en = 1'b1;
      @(negedge clk);                       // after mask edge
      bus_wr_en = 1'b0;
      check("R2 irq before output edge", {31'd0, cpu_irq}, 32'd0);
      @(negedge clk);
      check("R2 irq after mask write", {31'd0, cpu_irq}, 32'd1);

      // R1: no latching when line drops
      irq_lines = '0;
      settle();
      bus_read(32'h0C, 32'd0, "R1 pending cleared by level");
      check("R1 irq dropped", {31'd0, cpu_irq}, 32'd0);

      // R4: status not writable
      irq_lines = 24'h800001;
      bus_write(32'h04, 32'h0000_0001);
      settle();
      bus_write(32'h0C, 32'hFFFF_FFFF);
      bus_read(32'h0C, 32'h0080_0001, "R4 status write ignored");
      bus_read(32'h04, 32'h0000_0001, "R4 mask untouched by status write");

      // R5: level and ctrl writes change nothing
      bus_write(32'h00, 32'h0000_0000);
      bus_write(32'h14, 32'hFFFF_FFFF);
      bus_read(32'h04, 32'h0000_0001, "R5 mask after level/ctrl writes");
      check("R5 irq unchanged", {31'd0, cpu_irq}, 32'd1);

      // R6: other addresses
      bus_read(32'h00, 32'd0, "R6 read level offset");
      bus_read(32'h14, 32'd0, "R6 read ctrl offset");
      bus_read(32'h08, 32'd0, "R6 read hole");
      bus_read(32'h05, 32'd0, "R6 read unaligned");
      bus_write(32'h08, 32'h0000_0000);
      bus_write(32'h05, 32'h0000_0000);
      bus_read(32'h04, 32'h0000_0001, "R6 stray writes ignored");
      check("R6 irq unchanged", {31'd0, cpu_irq}, 32'd1);

      // R9: read and write of mask in one cycle
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = 32'h0000_0300;
      bus_wr_en = 1'b1; bus_rd_en = 1'b1;
      begin
         exp_t e;
         e.val = 32'h0000_0001;
         e.tag = "R9 read returns old mask";
         sb.push_back(e);
      end
      @(negedge clk);
      bus_wr_en = 1'b0; bus_rd_en = 1'b0;
      bus_read(32'h04, 32'h0000_0300, "R9 new mask visible next");
      irq_lines = '0;
      bus_write(32'h04, 32'h0);
      settle();

      // concurrent: pending rises on the same edge the mask is written
      @(negedge clk);
      irq_lines = 24'h000100;               // before E1
      @(negedge clk);                       // after E1
      @(negedge clk);                       // after E2
      bus_addr = 8'h04; bus_wdata = 32'h0000_0100; bus_wr_en = 1'b1;
      @(negedge clk);                       // after E3: mask and pending both new
      bus_wr_en = 1'b0;
      check("R2 coincident set, old value held", {31'd0, cpu_irq}, 32'd0);
      @(negedge clk);
      check("R2 coincident set, irq raised", {31'd0, cpu_irq}, 32'd1);

      // concurrent: pending falls on the same edge the mask is cleared
      @(negedge clk);
      irq_lines = '0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = 32'h0; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
      check("R2 coincident clear, old value held", {31'd0, cpu_irq}, 32'd1);
      @(negedge clk);
      check("R2 coincident clear, irq dropped", {31'd0, cpu_irq}, 32'd0);

      // R8: reset mid-run clears mask and output
      irq_lines = 24'h000002;
      bus_write(32'h04, 32'h0000_0002);
      settle();
      check("R8 irq before reset", {31'd0, cpu_irq}, 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 irq cleared by reset", {31'd0, cpu_irq}, 32'd0);
      rst_n = 1'b1;
      irq_lines = '0;
      bus_read(32'h04, 32'd0, "R8 mask cleared by reset");
      settle();
      check("R8 irq stays low", {31'd0, cpu_irq}, 32'd0);

      repeat (2) @(negedge clk);
      check("R7 all reads answered", sb.size(), 32'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule